// File: doc/BRIEF.md
# Stack and Register-Pair Execution Unit

This block runs the stack-pointer and register-pair subset of a classic 8-bit processor. It holds the stack pointer, the HL, BC and DE pairs, the accumulator and the flags byte. It takes one instruction per transfer on a valid/ready stream. Each beat carries an opcode byte and a 16-bit immediate field, and only the load-SP instruction uses the immediate. Register-only instructions complete on the clock edge that accepts them. Stack instructions are run as a series of byte-wide memory cycles on a request/ready port.

Back-pressure rules: an instruction transfers on a rising edge where `op_valid` and `op_ready` are both high. `op_ready` is low for the whole of a memory sequence. The source must hold `op_code` and `op_imm` steady while `op_valid` is high and `op_ready` is low. On the memory side a byte transfers on an edge where `mem_req` and `mem_ready` are both high. Read data is taken from `mem_rdata` in that same cycle. The memory may hold `mem_ready` low for as long as it needs.

The status word packs the accumulator into its upper byte and the flags into its lower byte. Carry is flags bit 0.

Top module: `stack_pair_unit`

## Requirements
- R1: Opcode 39h sets HL to the low 16 bits of HL+SP and flags bit 0 to bit 16 of that sum. All other flag bits are left as they were, and this happens on the accepting edge (4050h+5050h gives 90A0h with carry 0).
- R2: Opcode 33h adds one to SP and opcode 3Bh subtracts one from SP, both modulo 65536. Flags do not change (FFFFh+1 gives 0000h, 0000h-1 gives FFFFh).
- R3: Opcode 31h loads SP from `op_imm`, and opcode F9h copies HL into SP.
- R4: Opcodes C5h, D5h, E5h and F5h push BC, DE, HL and {A,flags}. The push writes the high byte at SP-1, then the low byte at SP-2, and SP ends two lower.
- R5: Opcodes C1h, D1h, E1h and F1h pop into BC, DE, HL and {A,flags}. The pop reads the low byte at SP, then the high byte at SP+1, and SP ends two higher. For F1h, A takes the high byte and flags take the low byte.
- R6: Opcode E3h runs four memory cycles in this order: read SP, read SP+1, write old L at SP, write old H at SP+1. Afterwards L and H hold the two bytes read, and SP is unchanged.
- R7: `busy` is high from the cycle after a stack opcode is accepted until its last memory byte transfers, and `op_ready` is low exactly while `busy` is high. A register-only opcode never raises `busy`.
- R8: While `mem_req` is high and `mem_ready` is low, the request stays up with `mem_addr`, `mem_we` and `mem_wdata` held, and no register changes.
- R9: Any opcode not listed in R1 to R6 is accepted and changes no register and starts no memory cycle.
- R10: After reset all registers read zero, `busy` and `mem_req` are low, and `op_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Instruction beat offered |
| op_ready | output | 1 | Unit can take an instruction |
| op_code | input | 8 | Opcode byte |
| op_imm | input | 16 | Immediate word for load-SP |
| busy | output | 1 | Memory sequence in progress |
| mem_req | output | 1 | Memory byte cycle requested |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with mem_ready |
| mem_ready | input | 1 | Memory completes the byte cycle |
| reg_sp | output | 16 | Stack pointer |
| reg_hl | output | 16 | HL pair |
| reg_bc | output | 16 | BC pair |
| reg_de | output | 16 | DE pair |
| reg_acc | output | 8 | Accumulator |
| reg_flags | output | 8 | Flags byte (bit 0 carry) |

## Verification
Two things can fall in the same cycle: the final memory byte of a stack sequence, and a new instruction already waiting on the input stream. To provoke this, the bench pushes a pair and then keeps `op_valid` high with an SP increment while the push is still running. It also inserts random and forced `mem_ready` stalls. The bench judges the result by the transfer log. Both push bytes must have transferred before the increment is taken, and the final SP must equal the push result plus one, so the increment is neither lost nor applied early.

// File: rtl/spu_pkg.sv
package spu_pkg;
  localparam int BYTE_W = 8;
  localparam int PAIR_W = 2 * BYTE_W;
  localparam int CY_BIT = 0;

  typedef enum logic [3:0] {
    K_NONE, K_DAD, K_INC, K_DEC, K_LDI, K_LDHL, K_XCHG, K_PUSH, K_POP
  } kind_t;

  typedef enum logic [1:0] {PR_BC = 2'd0, PR_DE = 2'd1, PR_HL = 2'd2, PR_PSW = 2'd3} pair_t;

  typedef struct packed {
    kind_t kind;
    pair_t pair;
  } dec_t;

  function automatic logic is_mem_kind(kind_t k);
    return (k == K_PUSH) || (k == K_POP) || (k == K_XCHG);
  endfunction
endpackage

// File: rtl/spu_decode.sv
module spu_decode
  import spu_pkg::*;
(
  input  logic [7:0] op_code,
  output dec_t       dec
);
  always_comb begin
    dec.kind = K_NONE;
    dec.pair = pair_t'(op_code[5:4]);
    unique case (op_code)
      8'h39:   dec.kind = K_DAD;
      8'h33:   dec.kind = K_INC;
      8'h3B:   dec.kind = K_DEC;
      8'h31:   dec.kind = K_LDI;
      8'hF9:   dec.kind = K_LDHL;
      8'hE3:   dec.kind = K_XCHG;
      default: begin
        if (op_code[7:6] == 2'b11 && op_code[3:0] == 4'h5) dec.kind = K_PUSH;
        else if (op_code[7:6] == 2'b11 && op_code[3:0] == 4'h1) dec.kind = K_POP;
      end
    endcase
  end
endmodule

// File: rtl/spu_regfile.sv
module spu_regfile
  import spu_pkg::*;
#(
  parameter int BW = BYTE_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sp_we,
  input  logic [2*BW-1:0] sp_d,
  input  logic            hl_we,
  input  logic [2*BW-1:0] hl_d,
  input  logic [3:0]      pair_we,
  input  logic [2*BW-1:0] pair_d,
  input  logic            cy_we,
  input  logic            cy_d,
  output logic [2*BW-1:0] sp_q,
  output logic [2*BW-1:0] hl_q,
  output logic [2*BW-1:0] bc_q,
  output logic [2*BW-1:0] de_q,
  output logic [BW-1:0]   a_q,
  output logic [BW-1:0]   f_q
);
  localparam int PW = 2 * BW;

  logic [PW-1:0] gp_q [2];

  // BC and DE are identical plain pairs written only by pop
  for (genvar g = 0; g < 2; g++) begin : g_pair
    always_ff @(posedge clk) begin
      if (!rst_n) gp_q[g] <= '0;
      else if (pair_we[g]) gp_q[g] <= pair_d;
    end
  end
  assign bc_q = gp_q[0];
  assign de_q = gp_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q <= '0;
      hl_q <= '0;
      a_q  <= '0;
      f_q  <= '0;
    end else begin
      if (sp_we) sp_q <= sp_d;
      if (hl_we) hl_q <= hl_d;
      else if (pair_we[PR_HL]) hl_q <= pair_d;
      if (pair_we[PR_PSW]) begin
        a_q <= pair_d[PW-1:BW];
        f_q <= pair_d[BW-1:0];
      end else if (cy_we) begin
        f_q[CY_BIT] <= cy_d;
      end
    end
  end
endmodule

// File: rtl/spu_seq.sv
module spu_seq
  import spu_pkg::*;
#(
  parameter int BW = BYTE_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  kind_t           start_kind,
  input  pair_t           start_pair,
  input  logic [2*BW-1:0] start_word,
  input  logic [2*BW-1:0] sp,
  output logic            mem_req,
  output logic            mem_we,
  output logic [2*BW-1:0] mem_addr,
  output logic [BW-1:0]   mem_wdata,
  input  logic [BW-1:0]   mem_rdata,
  input  logic            mem_ready,
  output logic            busy,
  output logic            done,
  output kind_t           done_kind,
  output pair_t           done_pair,
  output logic [2*BW-1:0] done_word
);
  localparam int PW = 2 * BW;

  logic          run_q;
  logic [1:0]    step_q;
  kind_t         kind_q;
  pair_t         pair_q;
  logic [PW-1:0] word_q;
  logic [PW-1:0] cap_q;
  logic          fire;
  logic [1:0]    last_step;
  logic [PW-1:0] step_off;

  assign fire      = run_q && mem_ready;
  assign last_step = (kind_q == K_XCHG) ? 2'd3 : 2'd1;
  assign done      = fire && (step_q == last_step);
  assign busy      = run_q;
  assign mem_req   = run_q;
  assign done_kind = kind_q;
  assign done_pair = pair_q;
  assign step_off  = PW'(step_q[0]);

  always_comb begin
    mem_we    = 1'b0;
    mem_addr  = sp + step_off;
    mem_wdata = word_q[PW-1:BW];
    unique case (kind_q)
      K_PUSH: begin
        mem_we    = 1'b1;
        mem_addr  = sp - (step_off + PW'(1));
        mem_wdata = step_q[0] ? word_q[BW-1:0] : word_q[PW-1:BW];
      end
      K_XCHG: begin
        mem_we    = step_q[1];
        mem_wdata = step_q[0] ? word_q[PW-1:BW] : word_q[BW-1:0];
      end
      default: ;
    endcase
  end

  always_comb begin
    if (kind_q == K_POP) done_word = {mem_rdata, cap_q[BW-1:0]};
    else done_word = cap_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      step_q <= '0;
      kind_q <= K_NONE;
      pair_q <= PR_BC;
      word_q <= '0;
      cap_q  <= '0;
    end else if (start) begin
      run_q  <= 1'b1;
      step_q <= '0;
      kind_q <= start_kind;
      pair_q <= start_pair;
      word_q <= start_word;
      cap_q  <= '0;
    end else if (fire) begin
      if (!mem_we) begin
        if (step_q[0]) cap_q[PW-1:BW] <= mem_rdata;
        else cap_q[BW-1:0] <= mem_rdata;
      end
      if (done) run_q <= 1'b0;
      else step_q <= step_q + 2'd1;
    end
  end
endmodule

// File: rtl/stack_pair_unit.sv
module stack_pair_unit
  import spu_pkg::*;
#(
  parameter int BW = BYTE_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  output logic            op_ready,
  input  logic [7:0]      op_code,
  input  logic [2*BW-1:0] op_imm,
  output logic            busy,
  output logic            mem_req,
  output logic            mem_we,
  output logic [2*BW-1:0] mem_addr,
  output logic [BW-1:0]   mem_wdata,
  input  logic [BW-1:0]   mem_rdata,
  input  logic            mem_ready,
  output logic [2*BW-1:0] reg_sp,
  output logic [2*BW-1:0] reg_hl,
  output logic [2*BW-1:0] reg_bc,
  output logic [2*BW-1:0] reg_de,
  output logic [BW-1:0]   reg_acc,
  output logic [BW-1:0]   reg_flags
);
  localparam int PW = 2 * BW;

  dec_t          dec;
  logic          accept;
  logic          start;
  logic [PW-1:0] pair_val;
  logic [PW:0]   dad_sum;
  logic          done;
  kind_t         done_kind;
  pair_t         done_pair;
  logic [PW-1:0] done_word;

  logic          sp_we, hl_we, cy_we, cy_d;
  logic [PW-1:0] sp_d, hl_d;
  logic [3:0]    pair_we;

  spu_decode i_dec (.op_code(op_code), .dec(dec));

  assign op_ready = !busy;
  assign accept   = op_valid && op_ready;
  assign start    = accept && is_mem_kind(dec.kind);
  assign dad_sum  = {1'b0, reg_hl} + {1'b0, reg_sp};

  always_comb begin
    unique case (dec.pair)
      PR_BC:   pair_val = reg_bc;
      PR_DE:   pair_val = reg_de;
      PR_HL:   pair_val = reg_hl;
      default: pair_val = {reg_acc, reg_flags};
    endcase
    if (dec.kind == K_XCHG) pair_val = reg_hl;
  end

  always_comb begin
    sp_we   = 1'b0;
    sp_d    = reg_sp;
    hl_we   = 1'b0;
    hl_d    = reg_hl;
    cy_we   = 1'b0;
    cy_d    = dad_sum[PW];
    pair_we = '0;
    if (accept) begin
      unique case (dec.kind)
        K_DAD:  begin hl_we = 1'b1; hl_d = dad_sum[PW-1:0]; cy_we = 1'b1; end
        K_INC:  begin sp_we = 1'b1; sp_d = reg_sp + PW'(1); end
        K_DEC:  begin sp_we = 1'b1; sp_d = reg_sp - PW'(1); end
        K_LDI:  begin sp_we = 1'b1; sp_d = op_imm; end
        K_LDHL: begin sp_we = 1'b1; sp_d = reg_hl; end
        default: ;
      endcase
    end
    if (done) begin
      unique case (done_kind)
        K_PUSH: begin sp_we = 1'b1; sp_d = reg_sp - PW'(2); end
        K_POP:  begin
          sp_we = 1'b1;
          sp_d  = reg_sp + PW'(2);
          pair_we[done_pair] = 1'b1;
        end
        K_XCHG: begin hl_we = 1'b1; hl_d = done_word; end
        default: ;
      endcase
    end
  end

  spu_regfile #(.BW(BW)) i_rf (
    .clk(clk), .rst_n(rst_n),
    .sp_we(sp_we), .sp_d(sp_d), .hl_we(hl_we), .hl_d(hl_d),
    .pair_we(pair_we), .pair_d(done_word), .cy_we(cy_we), .cy_d(cy_d),
    .sp_q(reg_sp), .hl_q(reg_hl), .bc_q(reg_bc), .de_q(reg_de),
    .a_q(reg_acc), .f_q(reg_flags)
  );

  spu_seq #(.BW(BW)) i_seq (
    .clk(clk), .rst_n(rst_n),
    .start(start), .start_kind(dec.kind), .start_pair(dec.pair),
    .start_word(pair_val), .sp(reg_sp),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .busy(busy), .done(done), .done_kind(done_kind), .done_pair(done_pair),
    .done_word(done_word)
  );
endmodule

// File: rtl/spu_checker.sv
module spu_checker #(
  parameter int BW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            op_valid,
  input logic            op_ready,
  input logic [7:0]      op_code,
  input logic            busy,
  input logic            mem_req,
  input logic            mem_we,
  input logic [2*BW-1:0] mem_addr,
  input logic [BW-1:0]   mem_wdata,
  input logic            mem_ready,
  input logic [2*BW-1:0] reg_sp,
  input logic [2*BW-1:0] reg_hl,
  input logic [BW-1:0]   reg_flags
);
  localparam int PW = 2 * BW;
  logic acc;
  assign acc = op_valid && op_ready;

  assert_dad_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op_code == 8'h39 |=> reg_hl == PW'($past(reg_hl) + $past(reg_sp)));

  assert_dad_carry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op_code == 8'h39 |=>
      reg_flags[0] == (({1'b0, $past(reg_hl)} + {1'b0, $past(reg_sp)}) >> PW));

  assert_inc_sp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op_code == 8'h33 |=> reg_sp == PW'($past(reg_sp) + 1));

  assert_ready_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !op_ready);

  assert_reg_op_no_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (op_code == 8'h33 || op_code == 8'h39 || op_code == 8'hF9) |=> !busy);

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                              && $stable(mem_wdata) && $stable(reg_sp));

  assert_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op_code == 8'h00 |=> $stable(reg_sp) && $stable(reg_hl) && !mem_req);

  assert_idle_no_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);
endmodule

bind stack_pair_unit spu_checker #(.BW(BW)) i_spu_checker (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
  .op_code(op_code), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
  .reg_sp(reg_sp), .reg_hl(reg_hl), .reg_flags(reg_flags)
);

// File: tb/test_stack_pair_unit.sv
module test_stack_pair_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [7:0]  op_code = 8'h00;
  logic [15:0] op_imm = 16'h0;
  logic        busy, mem_req, mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        mem_ready = 1'b0;
  logic [15:0] reg_sp, reg_hl, reg_bc, reg_de;
  logic [7:0]  reg_acc, reg_flags;

  int errors = 0;
  int checks = 0;
  bit stall_mode = 1'b0;

  always #2 clk = ~clk;

  stack_pair_unit i_stack_pair_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .op_imm(op_imm), .busy(busy), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .reg_sp(reg_sp),
    .reg_hl(reg_hl), .reg_bc(reg_bc), .reg_de(reg_de), .reg_acc(reg_acc),
    .reg_flags(reg_flags)
  );

  // bench memory (low address byte) and transfer log
  logic [7:0]  mem_arr [256];
  logic [15:0] lg_addr [16];
  logic        lg_we   [16];
  logic [7:0]  lg_wd   [16];
  int          lg_n;

  assign mem_rdata = mem_arr[mem_addr[7:0]];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem_arr[i] <= 8'h00;
      lg_n <= 0;
    end else if (mem_req && mem_ready) begin
      if (mem_we) mem_arr[mem_addr[7:0]] <= mem_wdata;
      lg_addr[lg_n % 16] <= mem_addr;
      lg_we[lg_n % 16]   <= mem_we;
      lg_wd[lg_n % 16]   <= mem_wdata;
      lg_n <= lg_n + 1;
    end
  end

  always @(negedge clk) mem_ready <= stall_mode ? 1'b0 : (($urandom % 4) != 0);

  // reference model
  logic [15:0] m_sp = 0, m_hl = 0, m_bc = 0, m_de = 0;
  logic [7:0]  m_a = 0, m_f = 0;
  logic [7:0]  em [256];
  int          ex_n;
  logic [15:0] ex_addr [4];
  logic        ex_we   [4];
  logic [7:0]  ex_wd   [4];

  initial for (int i = 0; i < 256; i++) em[i] = 8'h00;

  function automatic string tag_of(input logic [7:0] c);
    case (c)
      8'h39: return "R1";
      8'h33, 8'h3B: return "R2";
      8'h31, 8'hF9: return "R3";
      8'hC5, 8'hD5, 8'hE5, 8'hF5: return "R4";
      8'hC1, 8'hD1, 8'hE1, 8'hF1: return "R5";
      8'hE3: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic add_x(input logic [15:0] a, input logic w, input logic [7:0] d);
    ex_addr[ex_n] = a; ex_we[ex_n] = w; ex_wd[ex_n] = d; ex_n++;
  endtask

  task automatic model(input logic [7:0] c, input logic [15:0] imm);
    logic [16:0] s;
    logic [15:0] w;
    ex_n = 0;
    case (c)
      8'h39: begin s = {1'b0, m_hl} + {1'b0, m_sp}; m_hl = s[15:0]; m_f[0] = s[16]; end
      8'h33: m_sp = m_sp + 16'd1;
      8'h3B: m_sp = m_sp - 16'd1;
      8'h31: m_sp = imm;
      8'hF9: m_sp = m_hl;
      8'hE3: begin
        w = {em[8'(m_sp + 16'd1)], em[m_sp[7:0]]};
        add_x(m_sp, 1'b0, 8'h00);
        add_x(m_sp + 16'd1, 1'b0, 8'h00);
        add_x(m_sp, 1'b1, m_hl[7:0]);
        add_x(m_sp + 16'd1, 1'b1, m_hl[15:8]);
        em[m_sp[7:0]] = m_hl[7:0];
        em[8'(m_sp + 16'd1)] = m_hl[15:8];
        m_hl = w;
      end
      8'hC5, 8'hD5, 8'hE5, 8'hF5: begin
        case (c[5:4]) 2'd0: w = m_bc; 2'd1: w = m_de; 2'd2: w = m_hl; default: w = {m_a, m_f}; endcase
        add_x(m_sp - 16'd1, 1'b1, w[15:8]);
        add_x(m_sp - 16'd2, 1'b1, w[7:0]);
        em[8'(m_sp - 16'd1)] = w[15:8];
        em[8'(m_sp - 16'd2)] = w[7:0];
        m_sp = m_sp - 16'd2;
      end
      8'hC1, 8'hD1, 8'hE1, 8'hF1: begin
        w = {em[8'(m_sp + 16'd1)], em[m_sp[7:0]]};
        add_x(m_sp, 1'b0, 8'h00);
        add_x(m_sp + 16'd1, 1'b0, 8'h00);
        case (c[5:4]) 2'd0: m_bc = w; 2'd1: m_de = w; 2'd2: m_hl = w; default: {m_a, m_f} = w; endcase
        m_sp = m_sp + 16'd2;
      end
      default: ;
    endcase
  endtask

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic chk_regs(input string tag);
    chk(tag, "sp", reg_sp, m_sp);
    chk(tag, "hl", reg_hl, m_hl);
    chk(tag, "bc", reg_bc, m_bc);
    chk(tag, "de", reg_de, m_de);
    chk(tag, "acc", {8'h00, reg_acc}, {8'h00, m_a});
    chk(tag, "flags", {8'h00, reg_flags}, {8'h00, m_f});
  endtask

  task automatic chk_log(input string tag, input int start_n);
    chk(tag, "transfer count", 16'(lg_n - start_n), 16'(ex_n));
    for (int k = 0; k < ex_n && k < lg_n - start_n; k++) begin
      chk(tag, "addr", lg_addr[(start_n + k) % 16], ex_addr[k]);
      chk(tag, "we", {15'd0, lg_we[(start_n + k) % 16]}, {15'd0, ex_we[k]});
      if (ex_we[k]) chk(tag, "wdata", {8'h00, lg_wd[(start_n + k) % 16]}, {8'h00, ex_wd[k]});
    end
  endtask

  task automatic exec(input logic [7:0] c, input logic [15:0] imm, input bit stall);
    int   start_n;
    bit   is_mem;
    string tag;
    logic [15:0] a0;
    tag = tag_of(c);
    model(c, imm);
    is_mem = (ex_n != 0);
    if (stall) stall_mode = 1'b1;
    @(negedge clk);
    op_valid = 1'b1; op_code = c; op_imm = imm;
    while (!op_ready) @(negedge clk);
    start_n = lg_n;
    @(negedge clk);
    op_valid = 1'b0;
    chk("R7", "busy after accept", {15'd0, busy}, {15'd0, is_mem});
    if (stall && is_mem) begin
      a0 = mem_addr;
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        chk("R8", "req held", {15'd0, mem_req}, 16'd1);
        chk("R8", "addr held", mem_addr, a0);
      end
      stall_mode = 1'b0;
    end
    stall_mode = 1'b0;
    while (busy) @(negedge clk);
    chk("R7", "ready after done", {15'd0, op_ready}, 16'd1);
    chk_regs(tag);
    chk_log(tag, start_n);
  endtask

  // push with an SP increment waiting on the stream behind it
  task automatic overlap();
    int start_n;
    model(8'hD5, 16'h0);
    @(negedge clk);
    op_valid = 1'b1; op_code = 8'hD5;
    while (!op_ready) @(negedge clk);
    start_n = lg_n;
    @(negedge clk);
    op_code = 8'h33;
    while (!op_ready) @(negedge clk);
    chk("R7", "push bytes done before next accept", 16'(lg_n - start_n), 16'd2);
    chk("R4", "sp after push", reg_sp, m_sp);
    model(8'h33, 16'h0);
    @(negedge clk);
    op_valid = 1'b0;
    chk("R7", "sp after queued increment", reg_sp, m_sp);
    chk_regs("R2");
  endtask

  initial begin
    #(4 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  localparam logic [7:0] CODES [16] = '{8'h39, 8'h33, 8'h3B, 8'h31, 8'hF9, 8'hE3,
    8'hC5, 8'hD5, 8'hE5, 8'hF5, 8'hC1, 8'hD1, 8'hE1, 8'hF1, 8'h00, 8'h76};

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk_regs("R10");
    chk("R10", "busy", {15'd0, busy}, 16'd0);
    chk("R10", "mem_req", {15'd0, mem_req}, 16'd0);
    chk("R10", "op_ready", {15'd0, op_ready}, 16'd1);

    // R1 worked example and carry out
    exec(8'h31, 16'h4050, 1'b0);
    exec(8'h39, 16'h0, 1'b0);
    exec(8'h31, 16'h5050, 1'b0);
    exec(8'h39, 16'h0, 1'b0);
    chk("R1", "example sum", reg_hl, 16'h90A0);
    exec(8'h31, 16'hF000, 1'b0);
    exec(8'h39, 16'h0, 1'b0);
    chk("R1", "carry set", {15'd0, reg_flags[0]}, 16'd1);
    // R2 wrap both ways
    exec(8'h31, 16'hFFFF, 1'b0);
    exec(8'h33, 16'h0, 1'b0);
    chk("R2", "wrap up", reg_sp, 16'h0000);
    exec(8'h3B, 16'h0, 1'b0);
    chk("R2", "wrap down", reg_sp, 16'hFFFF);
    // R3 load from HL, stack push/pop/exchange with stalls
    exec(8'h31, 16'h0080, 1'b0);
    exec(8'hE5, 16'h0, 1'b1);
    exec(8'hF1, 16'h0, 1'b0);
    exec(8'hE5, 16'h0, 1'b0);
    exec(8'hC1, 16'h0, 1'b0);
    exec(8'hE5, 16'h0, 1'b0);
    exec(8'h39, 16'h0, 1'b0);
    exec(8'hE3, 16'h0, 1'b1);
    exec(8'h00, 16'h0, 1'b0);
    exec(8'hF9, 16'h0, 1'b0);
    overlap();

    for (int n = 0; n < 300; n++) begin
      logic [7:0] c;
      c = CODES[$urandom % 16];
      if (c == 8'h76) c = 8'($urandom);
      exec(c, 16'($urandom), ($urandom % 8) == 0);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule